// File: doc/BRIEF.md
# I2C Target Register Bridge

This block is the target side of a two-wire serial bus. It lets a bus host reach an internal register file and feed a transmit FIFO. A fast system clock samples the clock line and the data line. From those samples the block finds START, repeated START and STOP conditions. It then checks the 7-bit target address and latches a register sub-address byte. After that it moves data bytes between the bus and a simple register port, and it acknowledges each byte it takes.

One sub-address is special: it names the transmit-holding register, which feeds a downstream FIFO. When the FIFO reports full, a data byte aimed at that register is refused with a not-acknowledge and is thrown away. Every other write is acknowledged.

Reads use a repeated START. The host first writes the address and the sub-address, then sends the address again with the read bit set. The bridge returns one byte per read strobe until the host answers a byte with a not-acknowledge. The sub-address does not advance, so a burst keeps hitting the same register. This is the behaviour a FIFO port needs.

Top module: `i2c_reg_bridge`

## Requirements
- R1: While reset is held, and right after it, the data line is released (sda_oe = 0) and neither reg_wr nor reg_rd is asserted.
- R2: A STOP (data rising while the clock is high) returns the block to idle and releases the data line. The block then answers no traffic until a START (data falling while the clock is high).
- R3: The first byte after a START is seven address bits, MSB first, followed by a direction bit (0 = write, 1 = read). When the address equals DEV_ADDR, the block pulls the data line low for the ninth clock. Otherwise it leaves the line high.
- R4: The first byte written after a matching write address is latched as the sub-address and acknowledged. It drives reg_addr and stays fixed for every later data byte of the transfer, including those after a repeated START.
- R5: Each further written byte is acknowledged and produces one single-cycle reg_wr pulse, with the byte on reg_wdata.
- R6: When the latched sub-address equals THR_SUB and fifo_full is high, a data byte gets no acknowledge and produces no reg_wr pulse.
- R7: After a matching read address, the block returns reg_rdata of the latched sub-address MSB first. It issues one single-cycle reg_rd pulse for each byte.
- R8: When the host acknowledges a read byte, the next byte follows. When the host answers with a not-acknowledge, the block stops driving and the bus returns high.
- R9: The block changes its data-line drive only while the clock line is low.
- R10: A STOP or START in the middle of a byte abandons that byte. A START resumes address reception, so a following complete transfer works normally.
- R11: A transfer with a non-matching address writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| reg_addr | output | 8 | Latched register sub-address |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data of reg_addr, combinational from the register file |
| fifo_full | input | 1 | Downstream transmit FIFO is full |

## Verification
The assertions assume a well-behaved host. It changes the data line only while the clock is low, except when it makes a START or STOP, and it never makes a START or STOP while the target is pulling the data line low. The assertions also assume that each bus clock phase lasts several system clocks, longer than the two-flop synchronizer delay. The bench bit-bangs the host side with phases of 25 system clocks. It moves data 8 cycles after each falling clock, once the target has already updated its own drive. It makes every mid-byte abort while the data line is released.

// File: rtl/i2c_bridge_pkg.sv
// Shared types for the two-wire target register bridge.
package i2c_bridge_pkg;
    // Protocol phase of the bridge controller.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WR,
        ST_RD
    } br_state_t;
endpackage

// File: rtl/i2c_line_cond.sv
// Synchronises the bus clock and data lines into the system clock domain.
// Produces clock edges and START/STOP strobes from them.
// Assumes each bus phase lasts several system clocks; idle lines read high.
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] line_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Shift the raw line through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    // Hold the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '1;
        else        line_q <= synced;
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_rise  =  synced[1] & ~line_q[1];
    assign scl_fall  = ~synced[1] &  line_q[1];
    assign start_det =  synced[1] &  line_q[1] &  line_q[0] & ~synced[0];
    assign stop_det  =  synced[1] &  line_q[1] & ~line_q[0] &  synced[0];
endmodule

// File: rtl/i2c_ack_decide.sv
// Decides whether a received byte is acknowledged.
// It matches the address byte and blocks holding-register writes while the FIFO is full.
// Purely combinational; it assumes shift_byte holds a complete byte when it is consulted.
module i2c_ack_decide #(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter logic [7:0] THR_SUB  = 8'h00,
    parameter int         DW       = 8
) (
    input  logic [DW-1:0] shift_byte,
    input  logic [DW-1:0] sub_addr,
    input  logic          fifo_full,
    output logic          addr_hit,
    output logic          thr_block
);
    // Compare address bits and flag a refused FIFO write.
    always_comb begin
        addr_hit  = (shift_byte[DW-1:1] == DEV_ADDR);
        thr_block = fifo_full && (sub_addr == THR_SUB);
    end
endmodule

// File: rtl/i2c_reg_bridge.sv
// Two-wire bus target that bridges host transfers onto a register port.
// Assumes a system clock much faster than the bus clock; no clock stretching.
// The data line is driven open-drain through sda_oe, and only while the clock is low.
module i2c_reg_bridge
    import i2c_bridge_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter logic [7:0] THR_SUB     = 8'h00,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic       reg_wr,
    output logic [7:0] reg_wdata,
    output logic       reg_rd,
    input  logic [7:0] reg_rdata,
    input  logic       fifo_full
);
    localparam int DW    = 8;
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW);

    logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic            addr_hit, thr_block;
    br_state_t       state;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]   shreg;
    logic [DW-1:0]   sub_addr;
    logic            ack_phase;
    logic            rw;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_ack_decide #(.DEV_ADDR(DEV_ADDR), .THR_SUB(THR_SUB), .DW(DW)) u_ack (
        .shift_byte(shreg), .sub_addr(sub_addr), .fifo_full(fifo_full),
        .addr_hit(addr_hit), .thr_block(thr_block)
    );

    assign reg_addr = sub_addr;

    // Protocol controller: bit reception, acknowledge slots and read shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            sub_addr  <= '0;
            ack_phase <= 1'b0;
            sda_oe    <= 1'b0;
            rw        <= 1'b0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (stop_det) begin
                state     <= ST_IDLE;
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
                bit_cnt   <= '0;
            end else if (start_det) begin
                state     <= ST_ADDR;
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
                bit_cnt   <= '0;
            end else begin
                case (state)
                    ST_ADDR, ST_SUB, ST_WR: begin
                        if (!ack_phase) begin
                            if (scl_rise) begin
                                shreg   <= {shreg[DW-2:0], sda_s};
                                bit_cnt <= bit_cnt + 1'b1;
                            end else if (scl_fall && bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                if (state == ST_ADDR) begin
                                    if (addr_hit) begin
                                        ack_phase <= 1'b1;
                                        sda_oe    <= 1'b1;
                                        rw        <= shreg[0];
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else if (state == ST_SUB) begin
                                    ack_phase <= 1'b1;
                                    sda_oe    <= 1'b1;
                                    sub_addr  <= shreg;
                                end else begin
                                    ack_phase <= 1'b1;
                                    if (!thr_block) begin
                                        sda_oe    <= 1'b1;
                                        reg_wr    <= 1'b1;
                                        reg_wdata <= shreg;
                                    end
                                end
                            end
                        end else if (scl_fall) begin
                            ack_phase <= 1'b0;
                            sda_oe    <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (rw) begin
                                    state  <= ST_RD;
                                    shreg  <= reg_rdata;
                                    reg_rd <= 1'b1;
                                    sda_oe <= ~reg_rdata[DW-1];
                                end else begin
                                    state <= ST_SUB;
                                end
                            end else if (state == ST_SUB) begin
                                state <= ST_WR;
                            end
                        end
                    end
                    ST_RD: begin
                        if (!ack_phase) begin
                            if (scl_rise) begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end else if (scl_fall) begin
                                if (bit_cnt == LAST_BIT) begin
                                    ack_phase <= 1'b1;
                                    sda_oe    <= 1'b0;
                                    bit_cnt   <= '0;
                                end else begin
                                    shreg  <= {shreg[DW-2:0], 1'b0};
                                    sda_oe <= ~shreg[DW-2];
                                end
                            end
                        end else begin
                            if (scl_rise && sda_s) begin
                                state     <= ST_IDLE;
                                ack_phase <= 1'b0;
                            end else if (scl_fall) begin
                                ack_phase <= 1'b0;
                                shreg     <= reg_rdata;
                                reg_rd    <= 1'b1;
                                sda_oe    <= ~reg_rdata[DW-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_bridge_chk.sv
// Assertion checker for the register bridge, attached to it by bind.
// Assumes a host that only makes START/STOP while the target releases the line.
module i2c_reg_bridge_chk #(
    parameter logic [7:0] THR_SUB = 8'h00
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_addr,
    input logic       fifo_full,
    input logic       scl_s,
    input logic       stop_det
);
    // R1: quiet outputs after a reset cycle
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !reg_wr && !reg_rd));

    // R2: a STOP leaves the line released
    p_release_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4: the sub-address does not move while a write strobe is out
    p_sub_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $stable(reg_addr));

    // R5: write strobe lasts one cycle and never overlaps a read strobe
    p_write_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd}));

    // R6: no write into a full holding register
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !($past(fifo_full) && reg_addr == THR_SUB));

    // R7: read strobe lasts one cycle
    p_read_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R9: drive changes only while the clock line is low
    p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

bind i2c_reg_bridge i2c_reg_bridge_chk #(.THR_SUB(THR_SUB)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .fifo_full(fifo_full), .scl_s(scl_s), .stop_det(stop_det)
);

// File: tb/test_i2c_reg_bridge.sv
// Bench: bit-bangs a bus host against the bridge with a register-file model.
module test_i2c_reg_bridge;
    localparam logic [6:0] DEV = 7'h2A;
    localparam logic [7:0] THR = 8'h00;
    localparam int HP = 25;
    localparam int NV = 6;
    // {fifo_full, address, sub-address, data}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 7'h2A, 8'h05, 8'hA5},
        {1'b0, 7'h2A, 8'h10, 8'h3C},
        {1'b0, 7'h2A, 8'h00, 8'h77},
        {1'b1, 7'h2A, 8'h00, 8'h88},
        {1'b1, 7'h2A, 8'h07, 8'h5A},
        {1'b0, 7'h13, 8'h05, 8'hFF}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic scl = 1;
    logic host_low = 0;
    logic sda_bus;
    logic dut_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic reg_wr, reg_rd;
    logic fifo_full = 0;
    logic [7:0] regs [256];
    int fifo_cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int drive_viol = 0;
    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic dut_oe_q = 0;

    always #10 clk = ~clk;

    assign sda_bus   = ~(host_low | dut_oe);
    assign reg_rdata = regs[reg_addr];

    i2c_reg_bridge #(.DEV_ADDR(DEV), .THR_SUB(THR)) i_i2c_reg_bridge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(dut_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .fifo_full(fifo_full)
    );

    // Register-file and FIFO model; also watches when the drive changes.
    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt <= wr_cnt + 1;
            if (reg_addr == THR) fifo_cnt <= fifo_cnt + 1;
            else regs[reg_addr] <= reg_wdata;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (dut_oe !== dut_oe_q && scl) drive_viol <= drive_viol + 1;
        dut_oe_q <= dut_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_low = 1; w(HP); scl = 0; w(HP);
    endtask

    task automatic bus_restart();
        host_low = 0; w(HP); scl = 1; w(HP); host_low = 1; w(HP); scl = 0; w(HP);
    endtask

    task automatic bus_stop();
        host_low = 1; w(HP); scl = 1; w(HP); host_low = 0; w(HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            host_low = ~b[i]; w(HP); scl = 1; w(HP); scl = 0; w(8);
        end
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        host_low = 0; w(HP); scl = 1; w(HP / 2);
        ack = ~sda_bus;
        w(HP - HP / 2); scl = 0; w(8);
    endtask

    task automatic read_byte(input bit nack, output logic [7:0] b);
        host_low = 0;
        for (int i = 7; i >= 0; i--) begin
            w(HP); scl = 1; w(HP / 2); b[i] = sda_bus; w(HP - HP / 2); scl = 0; w(8);
        end
        host_low = ~nack; w(HP); scl = 1; w(HP); scl = 0; w(8); host_low = 0;
    endtask

    // Watchdog: an expired run is one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ack;
        bit exp_ack;
        logic [7:0] rb;
        int wc;
        int fc;
        for (int i = 0; i < 256; i++) regs[i] = 8'h00;
        w(5);
        // R1: reset state
        check(!dut_oe && !reg_wr && !reg_rd, "R1", {dut_oe, reg_wr, reg_rd}, 0);
        rst_n = 1; w(10);
        check(!dut_oe && sda_bus, "R1", dut_oe, 0);

        // Vector table: one write transfer per entry.
        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            e = VEC[v];
            fifo_full = e[23];
            wc = wr_cnt; fc = fifo_cnt;
            bus_start();
            write_byte({e[22:16], 1'b0}, ack);
            check(ack == (e[22:16] == DEV), "R3", ack, e[22:16] == DEV);
            write_byte(e[15:8], ack);
            if (e[22:16] == DEV) check(ack, "R4", ack, 1);
            exp_ack = (e[22:16] == DEV) && !(e[15:8] == THR && e[23]);
            write_byte(e[7:0], ack);
            if (e[22:16] == DEV) check(ack == exp_ack, "R6", ack, exp_ack);
            bus_stop(); w(10);
            check(!dut_oe, "R2", dut_oe, 0);
            if (e[22:16] != DEV)
                check(wr_cnt == wc && regs[e[15:8]] == 8'hA5, "R11", regs[e[15:8]], 8'hA5);
            else if (e[15:8] == THR)
                check(fifo_cnt == fc + (exp_ack ? 1 : 0), "R6", fifo_cnt, fc + (exp_ack ? 1 : 0));
            else
                check(regs[e[15:8]] == e[7:0], "R5", regs[e[15:8]], e[7:0]);
        end
        fifo_full = 0;

        // R4: burst into the holding register keeps the same sub-address.
        fc = fifo_cnt;
        bus_start();
        write_byte({DEV, 1'b0}, ack); write_byte(THR, ack);
        for (int k = 0; k < 3; k++) write_byte(8'h40 + 8'(k), ack);
        bus_stop(); w(10);
        check(fifo_cnt == fc + 3, "R4", fifo_cnt, fc + 3);

        // R7/R8: read two bytes from 0x10 via repeated START.
        wc = rd_cnt;
        bus_start();
        write_byte({DEV, 1'b0}, ack); write_byte(8'h10, ack);
        bus_restart();
        write_byte({DEV, 1'b1}, ack);
        check(ack, "R3", ack, 1);
        read_byte(1'b0, rb);
        check(rb == 8'h3C, "R7", rb, 8'h3C);
        read_byte(1'b1, rb);
        check(rb == 8'h3C, "R8", rb, 8'h3C);
        check(sda_bus && !dut_oe, "R8", dut_oe, 0);
        bus_stop(); w(10);
        check(rd_cnt == wc + 2, "R7", rd_cnt, wc + 2);

        // R10: STOP in the middle of an address byte, then a clean transfer.
        bus_start();
        send_bits({DEV, 1'b0}, 4);
        bus_stop(); w(10);
        check(!dut_oe, "R10", dut_oe, 0);
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        check(ack, "R10", ack, 1);
        write_byte(8'h22, ack); write_byte(8'h61, ack);
        bus_stop(); w(10);
        check(regs[8'h22] == 8'h61, "R10", regs[8'h22], 8'h61);

        // R10: START in the middle of the sub-address byte resumes address reception.
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        send_bits(8'hF0, 3);
        bus_restart();
        write_byte({DEV, 1'b0}, ack);
        check(ack, "R10", ack, 1);
        write_byte(8'h30, ack); write_byte(8'h99, ack);
        bus_stop(); w(10);
        check(regs[8'h30] == 8'h99, "R10", regs[8'h30], 8'h99);

        // R2: traffic after a non-matching address is ignored until START.
        wc = wr_cnt;
        bus_start();
        write_byte({7'h55, 1'b0}, ack);
        write_byte(8'h00, ack);
        check(!ack, "R2", ack, 0);
        bus_stop(); w(10);
        check(wr_cnt == wc, "R11", wr_cnt, wc);

        // R9: drive changed only while the clock line was low.
        check(drive_viol == 0, "R9", drive_viol, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule